// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the bus-facing part of a 512-byte serial memory. It watches a two-wire bus, clock and data, sampled by a fast system clock. It spots start and stop conditions and checks the select byte against its device code and its two chip-select pins. It then runs the transfer. On a write, the transfer carries an address byte and then data bytes. On a read, it shifts bytes out from an internal 9-bit address counter. It pulls the data line low through a single open-drain enable.

Write bytes go out one at a time to an external write controller. Each one comes with the counter value as its address. A stop that ends a write with at least one data byte pulses a commit strobe. While the controller reports a write cycle in progress, the front end stays off the bus. A master can therefore poll the select byte until the memory acknowledges again.

The select byte carries, MSB first, a 4-bit device code, two chip-select bits, a block bit and a read flag. The block bit becomes bit 8 of the address that a write transfer loads.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), no write or commit strobe is raised and the address counter is 0.
- R2: A select byte is acknowledged (data held low through the 9th clock) only when bits 7:4 equal 4'b1010 and bits 3:2 equal `chip_sel`. Otherwise it gets no acknowledge, and the rest of the transfer is ignored until the next start.
- R3: After a write select (bit 0 = 0), the next byte is acknowledged and loads the counter with {select bit 1, byte}.
- R4: Each further write byte is acknowledged and raises `wr_valid` for exactly one cycle, with `wr_data` = the byte and `mem_addr` = the counter. The counter then steps by one, wrapping 0x1FF to 0x000.
- R5: A stop pulses `wr_commit` for one cycle only if the transfer handed out at least one data byte. A transfer cut off by a repeated start never commits.
- R6: A read select (bit 0 = 1) with no address phase returns the byte at the counter, MSB first, and then steps the counter. The block bit of a read select is ignored.
- R7: A write select plus address byte, followed by a repeated start and a read select, returns the byte at the address just loaded.
- R8: While the master acknowledges, read bytes continue from consecutive addresses, and 0x1FF is followed by 0x000.
- R9: After the master leaves a read byte unacknowledged, the slave releases the line and does not drive it on any later clock until a new start.
- R10: While `wr_busy` is high, the block acknowledges nothing, hands out no byte and leaves the counter unchanged. Once it drops, a select byte is acknowledged again.
- R11: `sda_oe` changes only while the bus clock is low.
- R12: A start seen partway through a byte abandons it and restarts bit counting with a new select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| chip_sel | input | 2 | Expected select bits 3:2 |
| wr_busy | input | 1 | Write controller is running a write cycle |
| mem_rdata | input | 8 | Memory byte at `mem_addr` |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | 9 | Address counter, for reads and writes |
| wr_valid | output | 1 | One-cycle strobe: `wr_data` goes to `mem_addr` |
| wr_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-cycle strobe: start the write cycle |

## Verification
Select bytes with a wrong chip-select field and with a wrong device code show that both fields are compared. A five-byte write starting at 0x1FC shows that the counter wraps on writes. A random read that continues across 0x1FF shows that the loaded address is used and that it wraps on reads. A current-address read then shows that the counter keeps its value between transfers. Polling during and after the busy window separates refusal from acceptance. Repeated starts partway through an address byte and after a data byte show, in turn, that bit counting resynchronises and that an abandoned write never commits.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] chip_sel,
  input  logic       wr_busy,
  input  logic [7:0] mem_rdata,
  output logic       sda_oe,
  output logic [8:0] mem_addr,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       wr_commit
);
  localparam int BITS = 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_RDATA} st_t;

  st_t        st;
  logic       scl_s, sda_s, scl_p, sda_p;
  logic [3:0] cnt;
  logic       in_ack, mack, blk, rw, wr_any;
  logic [7:0] shreg, tx;

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire dev_hit  = (shreg[7:4] == DEV_CODE) && (shreg[3:2] == chip_sel);
  wire byte_end = (cnt == 4'(BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 1'b1; sda_s <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= scl_i; sda_s <= sda_i; scl_p <= scl_s; sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; in_ack <= 1'b0; mack <= 1'b0;
      blk <= 1'b0; rw <= 1'b0; wr_any <= 1'b0;
      shreg <= '0; tx <= '0; sda_oe <= 1'b0; mem_addr <= '0;
      wr_valid <= 1'b0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (wr_valid) mem_addr <= mem_addr + 9'd1;
      if (wr_busy) begin
        st <= S_IDLE; sda_oe <= 1'b0; in_ack <= 1'b0; wr_any <= 1'b0;
      end else if (start_ev) begin
        st <= S_DEV; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0; wr_any <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0; in_ack <= 1'b0;
        wr_commit <= wr_any; wr_any <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (in_ack) mack <= ~sda_s;
          else begin
            cnt <= cnt + 4'd1;
            if (st != S_RDATA) shreg <= {shreg[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (!in_ack && byte_end) begin
            in_ack <= 1'b1;
            case (st)
              S_DEV: if (dev_hit) begin
                       sda_oe <= 1'b1; blk <= shreg[1]; rw <= shreg[0];
                     end else st <= S_IDLE;
              S_ADDR:  begin sda_oe <= 1'b1; mem_addr <= {blk, shreg}; end
              S_WDATA: begin
                         sda_oe <= 1'b1; wr_valid <= 1'b1;
                         wr_data <= shreg; wr_any <= 1'b1;
                       end
              default: sda_oe <= 1'b0;
            endcase
          end else if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            case (st)
              S_DEV: if (rw) begin
                       st <= S_RDATA; tx <= mem_rdata;
                       sda_oe <= ~mem_rdata[7]; mem_addr <= mem_addr + 9'd1;
                     end else begin
                       st <= S_ADDR; sda_oe <= 1'b0;
                     end
              S_ADDR:  begin st <= S_WDATA; sda_oe <= 1'b0; end
              S_RDATA: if (mack) begin
                         tx <= mem_rdata; sda_oe <= ~mem_rdata[7];
                         mem_addr <= mem_addr + 9'd1;
                       end else begin
                         st <= S_IDLE; sda_oe <= 1'b0;
                       end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == S_RDATA) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wr_valid,
  input logic       wr_commit,
  input logic       wr_busy,
  input logic [8:0] mem_addr
);
  assert_oe_quiet_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  assert_wr_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_addr_steps_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid) |-> (mem_addr == $past(mem_addr) + 9'd1));

  assert_commit_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_busy_keeps_off_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_busy) |-> (!sda_oe && !wr_valid && !wr_commit));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_commit(wr_commit), .wr_busy(wr_busy),
  .mem_addr(mem_addr)
);

// File: tb/sim_i2c_eeprom_slave.sv
module sim_i2c_eeprom_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] chip_sel = 2'b10;
  logic sda_oe, wr_valid, wr_commit, wr_busy;
  logic [8:0] mem_addr;
  logic [7:0] wr_data, mem_rdata;
  logic [7:0] bmem [512];
  logic sda_line;
  int n_chk = 0, n_bad = 0, commits = 0, busy_cnt = 0;
  logic [16:0] exp_q [$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line  = m_sda & ~sda_oe;
  assign wr_busy   = (busy_cnt != 0);
  assign mem_rdata = bmem[mem_addr];

  i2c_eeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .chip_sel(chip_sel), .wr_busy(wr_busy), .mem_rdata(mem_rdata),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_commit(wr_commit)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write controller model and write expectation queue
  always @(negedge clk) begin
    if (wr_commit) begin commits++; busy_cnt = 300; end
    else if (busy_cnt > 0) busy_cnt--;
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected write strobe", int'(mem_addr), -1);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, wr_data} == e, "R4", "write addr/data", int'({mem_addr, wr_data}), int'(e));
      end
      bmem[mem_addr] = wr_data;
    end
  end

  task automatic bus_start();
    if (m_scl == 1'b0) begin m_sda = 1'b1; wait_n(3); m_scl = 1'b1; wait_n(3); end
    m_sda = 1'b0; wait_n(3); m_scl = 1'b0; wait_n(3);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(3); m_scl = 1'b1; wait_n(3); m_sda = 1'b1; wait_n(3);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    logic o1, o2;
    m_sda = b; wait_n(3);
    m_scl = 1'b1; wait_n(3);
    o1 = sda_oe; r = sda_line;
    wait_n(2);
    o2 = sda_oe;
    chk(o1 == o2, "R11", "drive changed while clock high", o2, o1);
    m_scl = 1'b0; wait_n(3);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    chk(r == !exp_ack, req, "acknowledge level", r, !exp_ack);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit m_ack, input string req);
    logic r;
    logic [7:0] got = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, r); got = {got[6:0], r}; end
    clk_bit(!m_ack, r);
    chk(got == exp, req, "read byte", got, exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic r;
    logic [8:0] ma;
    logic [7:0] wd [5];
    for (int i = 0; i < 512; i++) bmem[i] = 8'((i * 37 + 5) & 255);
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44; wd[4] = 8'h55;
    wait_n(5); rst_n = 1'b1; wait_n(3);

    chk(sda_oe == 0, "R1", "sda_oe after reset", sda_oe, 0);
    chk(wr_valid == 0 && wr_commit == 0, "R1", "strobes after reset", wr_valid, 0);
    chk(mem_addr == 0, "R1", "counter after reset", mem_addr, 0);

    // R2: wrong chip-select field, then wrong device code
    bus_start(); send_byte(8'b1010_01_0_0, 0, "R2"); send_byte(8'h12, 0, "R2"); bus_stop();
    bus_start(); send_byte(8'b1011_10_0_0, 0, "R2"); bus_stop();
    wait_n(2); chk(commits == 0, "R2", "commit after refused select", commits, 0);

    // R3/R4: write of five bytes from 0x1FC, wrapping
    bus_start(); send_byte(8'b1010_10_1_0, 1, "R2");
    send_byte(8'hFC, 1, "R3");
    chk(mem_addr == 9'h1FC, "R3", "loaded address", mem_addr, 9'h1FC);
    ma = 9'h1FC;
    for (int i = 0; i < 5; i++) begin
      exp_q.push_back({ma, wd[i]}); send_byte(wd[i], 1, "R4"); ma = ma + 9'd1;
    end
    wait_n(2);
    chk(exp_q.size() == 0, "R4", "pending writes", exp_q.size(), 0);
    chk(mem_addr == 9'h001, "R4", "counter after wrap", mem_addr, 1);
    bus_stop(); wait_n(2);
    chk(commits == 1, "R5", "commit after data", commits, 1);

    // R10: poll while busy, then after
    bus_start(); send_byte(8'b1010_10_0_0, 0, "R10"); send_byte(8'h40, 0, "R10"); bus_stop();
    chk(mem_addr == 9'h001, "R10", "counter during busy", mem_addr, 1);
    while (wr_busy) wait_n(1);
    wait_n(4);
    bus_start(); send_byte(8'b1010_10_0_0, 1, "R10"); bus_stop(); wait_n(2);
    chk(commits == 1, "R5", "commit without data", commits, 1);

    // R7/R8: random read at 0x1FD continuing across the wrap
    bus_start(); send_byte(8'b1010_10_1_0, 1, "R7"); send_byte(8'hFD, 1, "R7");
    bus_start(); send_byte(8'b1010_10_1_1, 1, "R7");
    recv_byte(8'h22, 1, "R7");
    recv_byte(8'h33, 1, "R8");
    recv_byte(8'h44, 1, "R8");
    recv_byte(8'h55, 0, "R8");
    // R9: clocks after master NACK see a released line
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, r); chk(r == 1'b1, "R9", "line after NACK", r, 1);
    end
    bus_stop();
    chk(mem_addr == 9'h001, "R8", "counter after wrapped read", mem_addr, 1);

    // R6: current-address read
    bus_start(); send_byte(8'b1010_10_0_1, 1, "R6"); recv_byte(bmem[1], 0, "R6"); bus_stop();
    chk(mem_addr == 9'h002, "R6", "counter after read", mem_addr, 2);

    // R12: start partway through an address byte
    bus_start(); send_byte(8'b1010_10_0_0, 1, "R12");
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
    bus_start(); send_byte(8'b1010_10_0_1, 1, "R12"); recv_byte(bmem[2], 0, "R12"); bus_stop();

    // R5: write cut off by repeated start never commits
    bus_start(); send_byte(8'b1010_10_0_0, 1, "R5"); send_byte(8'h10, 1, "R3");
    exp_q.push_back({9'h010, 8'h99}); send_byte(8'h99, 1, "R4");
    bus_start(); send_byte(8'b1010_10_0_1, 1, "R5"); recv_byte(bmem[9'h011], 0, "R5"); bus_stop();
    wait_n(3);
    chk(commits == 1, "R5", "commit after aborted write", commits, 1);
    chk(bmem[9'h010] == 8'h99, "R4", "byte handed out", bmem[9'h010], 8'h99);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule